// File: doc/BRIEF.md
# Negotiation Progress and Sticky Error Status Register

This block is one status word in the management register space of a 10/100 Ethernet PHY. It watches the live state code of the link negotiation engine and keeps the highest code seen, so software can tell how far negotiation got between two polls. A management read returns that held maximum. The same read then reloads the held value with the state the engine is in at that moment. The next read therefore shows progress made after the first read, not the whole history since reset.

The word also carries two error bits that latch high. One records loss of the 100 Mb/s receive signal. The other records a failure of the receive PLL to lock onto the 100 Mb/s stream. Each stays set until a read or a reset clears it. In 10 Mb/s mode these two bits have no meaning, so they read as 0 and their event strobes are dropped.

All pins are plain control and status signals. There is no data stream and no back-pressure: a read is a single-cycle strobe from the management interface logic, and the word is visible on `status_word` in every cycle.

Top module: `anpm_status_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives every bit of `status_word` to 0 from the next cycle onward.
- R2: The live state code on `an_state` means: 0 Idle, 1 parallel detected, 2 parallel detection failed, 3 abilities matched, 4 acknowledge match failed, 5 acknowledge matched, 6 consistency match failed, 7 consistency matched, 8 negotiation completed. Codes 9 to 15 are treated as 8. While `an_enable` is high and no read occurs, the held code changes at a clock edge only when the live code is greater than the held code.
- R3: In a cycle with `rd_strobe` high, `status_word` shows the held code from before the read. At that edge, if `an_enable` is high, the held code is loaded with the live code, even when the live code is lower.
- R4: Bits 13:11 show the held code saturated to 3 bits: code 8 shows 111. Bit 4 is 1 exactly when the held code is 8.
- R5: An edge with `an_enable` low sets the held code to Idle (0), so bits 13:11 and bit 4 read 0 in the next cycle.
- R6: Bit 10 (receive signal lost) is set at an edge where `rx_lost_evt` is high and `mode_100` is high. It stays set through later edges until an edge with `rd_strobe` high, which clears it.
- R7: Bit 9 (PLL lock error) is set at an edge where `pll_err_evt` is high and `mode_100` is high. It stays set through later edges until an edge with `rd_strobe` high, which clears it.
- R8: When an event strobe and `rd_strobe` are both high in the same cycle, the read sees the old flag value and the flag is 1 after the edge.
- R9: While `mode_100` is low (10 Mb/s), bits 10 and 9 read 0. Event strobes in that mode are ignored, and any stored flag is cleared, so both bits read 0 after a return to 100 Mb/s until a new event occurs.
- R10: Bits 15:14, 8:5 and 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| an_enable | input | 1 | Negotiation enabled |
| an_state | input | 4 | Live negotiation state code |
| mode_100 | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| rx_lost_evt | input | 1 | Strobe: 100 Mb/s receive signal lost |
| pll_err_evt | input | 1 | Strobe: PLL failed to lock |
| rd_strobe | input | 1 | Single-cycle management read of this word |
| status_word | output | 16 | Register word |

## Verification
The hardest situation to reach is a read that reloads a lower live code and is then followed by a climb. It has to be shown that the held value drops at the read and then rises again only past the reload point. In the same area, a read has to coincide with an event strobe in the same cycle. Directed sequences build both cases by hand: climb to completion, read while the engine has fallen back, climb again, and pulse an event together with a read. The random phase then biases reads and strobes so that these overlaps, and switches between the two speed modes, occur many times with codes above 8 mixed in.

// File: rtl/anpm_pkg.sv
package anpm_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NUM_FLAGS = 2;
  // bit positions in the word (decoded by management software)
  localparam int unsigned FIELD_LSB = 11;
  localparam int unsigned RXL_BIT   = 10;
  localparam int unsigned PLL_BIT   = 9;
  localparam int unsigned DONE_BIT  = 4;

  typedef enum logic [CODE_W-1:0] {
    AN_IDLE      = 4'd0,
    AN_PAR_DET   = 4'd1,
    AN_PAR_FAIL  = 4'd2,
    AN_ABIL_OK   = 4'd3,
    AN_ACK_FAIL  = 4'd4,
    AN_ACK_OK    = 4'd5,
    AN_CONS_FAIL = 4'd6,
    AN_CONS_OK   = 4'd7,
    AN_DONE      = 4'd8
  } an_prog_e;

  function automatic an_prog_e clamp_code(input logic [CODE_W-1:0] c);
    if (c > AN_DONE) return AN_DONE;
    return an_prog_e'(c);
  endfunction
endpackage

// File: rtl/anpm_progress_track.sv
module anpm_progress_track
  import anpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              an_enable,
  input  logic [CODE_W-1:0] live_code,
  input  logic              rd_strobe,
  output an_prog_e          held_code
);
  an_prog_e live_sat;

  always_comb live_sat = clamp_code(live_code);

  always_ff @(posedge clk) begin
    if (rst)                   held_code <= AN_IDLE;
    else if (!an_enable)       held_code <= AN_IDLE;
    else if (rd_strobe)        held_code <= live_sat;
    else if (live_sat > held_code) held_code <= live_sat;
  end
endmodule

// File: rtl/anpm_sticky_flag.sv
module anpm_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic mode_100,
  input  logic evt,
  input  logic rd_strobe,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (!mode_100) flag <= 1'b0;
    else if (evt)       flag <= 1'b1;
    else if (rd_strobe) flag <= 1'b0;
  end
endmodule

// File: rtl/anpm_word_pack.sv
module anpm_word_pack
  import anpm_pkg::*;
(
  input  an_prog_e               held_code,
  input  logic [NUM_FLAGS-1:0]   flags,
  input  logic                   mode_100,
  output logic [WORD_W-1:0]      word
);
  localparam logic [FIELD_W-1:0] FIELD_MAX = '1;
  logic [FIELD_W-1:0] field;

  always_comb begin
    if (held_code >= an_prog_e'(FIELD_MAX)) field = FIELD_MAX;
    else                                    field = held_code[FIELD_W-1:0];
    word = '0;
    word[FIELD_LSB +: FIELD_W] = field;
    word[DONE_BIT]             = (held_code == AN_DONE);
    word[RXL_BIT]              = flags[0] & mode_100;
    word[PLL_BIT]              = flags[1] & mode_100;
  end
endmodule

// File: rtl/anpm_status_reg.sv
module anpm_status_reg
  import anpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              an_enable,
  input  logic [CODE_W-1:0] an_state,
  input  logic              mode_100,
  input  logic              rx_lost_evt,
  input  logic              pll_err_evt,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] status_word
);
  an_prog_e             held_code;
  logic [NUM_FLAGS-1:0] evt_vec;
  logic [NUM_FLAGS-1:0] flags;

  assign evt_vec = {pll_err_evt, rx_lost_evt};

  anpm_progress_track u_track (
    .clk       (clk),
    .rst       (rst),
    .an_enable (an_enable),
    .live_code (an_state),
    .rd_strobe (rd_strobe),
    .held_code (held_code)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    anpm_sticky_flag u_flag (
      .clk       (clk),
      .rst       (rst),
      .mode_100  (mode_100),
      .evt       (evt_vec[i]),
      .rd_strobe (rd_strobe),
      .flag      (flags[i])
    );
  end

  anpm_word_pack u_pack (
    .held_code (held_code),
    .flags     (flags),
    .mode_100  (mode_100),
    .word      (status_word)
  );
endmodule

// File: rtl/anpm_status_chk.sv
module anpm_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        an_enable,
  input logic        mode_100,
  input logic        rx_lost_evt,
  input logic        pll_err_evt,
  input logic        rd_strobe,
  input logic [15:0] status_word
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> status_word == 16'h0);
  // R2
  progress_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (an_enable && !rd_strobe) |=> status_word[13:11] >= $past(status_word[13:11]));
  // R4
  done_sat_chk: assert property (@(posedge clk) disable iff (rst)
    status_word[4] |-> status_word[13:11] == 3'b111);
  // R5
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !an_enable |=> (status_word[13:11] == 3'b000 && !status_word[4]));
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_100 && status_word[10] && !rd_strobe) |=> (status_word[10] || !mode_100));
  // R6
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_100 && rx_lost_evt) |=> (status_word[10] || !mode_100));
  // R7
  pll_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_100 && pll_err_evt) |=> (status_word[9] || !mode_100));
  // R8
  rd_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_100 && rd_strobe && pll_err_evt) |=> (status_word[9] || !mode_100));
  // R9
  slow_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_100 |-> status_word[10:9] == 2'b00);
  // R10
  spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status_word[15:14] == 2'b00 && status_word[8:5] == 4'h0 && status_word[3:0] == 4'h0));
endmodule

bind anpm_status_reg anpm_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .an_enable   (an_enable),
  .mode_100    (mode_100),
  .rx_lost_evt (rx_lost_evt),
  .pll_err_evt (pll_err_evt),
  .rd_strobe   (rd_strobe),
  .status_word (status_word)
);

// File: tb/anpm_status_reg_bench.sv
`timescale 1ns/1ps
module anpm_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        an_enable = 1'b0;
  logic [3:0]  an_state = 4'd0;
  logic        mode_100 = 1'b1;
  logic        rx_lost_evt = 1'b0;
  logic        pll_err_evt = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [15:0] status_word;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int m_code = 0;
  bit m_rx = 0, m_pll = 0;

  always #2.5 clk = ~clk;

  anpm_status_reg u_anpm_status_reg (
    .clk(clk), .rst(rst), .an_enable(an_enable), .an_state(an_state),
    .mode_100(mode_100), .rx_lost_evt(rx_lost_evt), .pll_err_evt(pll_err_evt),
    .rd_strobe(rd_strobe), .status_word(status_word)
  );

  function automatic int sat8(input int c);
    return (c > 8) ? 8 : c;
  endfunction

  function automatic logic [2:0] exp_field(input int c);
    return (c >= 7) ? 3'd7 : c[2:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit en, input int code, input bit rd,
                      input bit rxe, input bit ple, input bit md);
    string tf, tx;
    @(negedge clk);
    rst = r; an_enable = en; an_state = code[3:0]; rd_strobe = rd;
    rx_lost_evt = rxe; pll_err_evt = ple; mode_100 = md;
    @(posedge clk);
    if (r) begin
      m_code = 0; m_rx = 0; m_pll = 0;
    end else begin
      if (!en)                 m_code = 0;
      else if (rd)             m_code = sat8(code);
      else if (sat8(code) > m_code) m_code = sat8(code);
      if (!md) begin m_rx = 0; m_pll = 0; end
      else begin
        if (rxe) m_rx = 1; else if (rd) m_rx = 0;
        if (ple) m_pll = 1; else if (rd) m_pll = 0;
      end
    end
    #1;
    tf = r ? "R1" : (!en ? "R5" : (rd ? "R3" : "R2"));
    tx = r ? "R1" : (!md ? "R9" : ((rd && (rxe || ple)) ? "R8" : "R6"));
    check(tf, {13'h0, status_word[13:11]}, {13'h0, exp_field(m_code)});
    check(r ? "R1" : "R4", {15'h0, status_word[4]}, {15'h0, (m_code == 8)});
    check(tx, {15'h0, status_word[10]}, {15'h0, m_rx & md});
    check(tx == "R6" ? "R7" : tx, {15'h0, status_word[9]}, {15'h0, m_pll & md});
    check("R10", status_word & 16'hC1EF, 16'h0);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R1 reset
    step(1, 0, 0, 0, 0, 0, 1);
    step(1, 1, 5, 0, 1, 1, 1);
    // R2 climb through all codes, R4 saturation at completion
    for (int c = 0; c <= 8; c++) step(0, 1, c, 0, 0, 0, 1);
    // R2 lower codes do not lower the field
    step(0, 1, 3, 0, 0, 0, 1);
    step(0, 1, 12, 0, 0, 0, 1);
    // R3 read reloads lower live code, then climb again
    step(0, 1, 2, 1, 0, 0, 1);
    step(0, 1, 1, 0, 0, 0, 1);
    step(0, 1, 4, 0, 0, 0, 1);
    // R6 R7 set and hold, R8 event with read
    step(0, 1, 4, 0, 1, 0, 1);
    step(0, 1, 4, 0, 0, 1, 1);
    step(0, 1, 4, 0, 0, 0, 1);
    step(0, 1, 4, 1, 0, 1, 1);
    step(0, 1, 4, 1, 0, 0, 1);
    // R9 10 Mb/s ignores events and clears
    step(0, 1, 4, 0, 1, 1, 1);
    step(0, 1, 4, 0, 1, 1, 0);
    step(0, 1, 4, 0, 0, 0, 1);
    // R5 disable returns to idle
    step(0, 0, 8, 0, 0, 0, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 200) == 0, ($urandom % 10) != 0, $urandom % 16,
           ($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 8) != 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule